// File: doc/BRIEF.md
# Triggered Circular Trace Controller

This block runs one triggered capture into a circular sample buffer. A start pulse arms it, reloads the write pointer with a programmed start address and issues a "waiting" status record. From then on every valid input sample goes straight to the buffer memory port at the write pointer. The pointer wraps modulo the buffer depth, so the oldest data is overwritten until the capture ends.

After a programmed number of samples has been written, the trigger qualifier arms. It requires the masked channels to miss their target levels for an intro number of samples, and then to match them for an outro number of samples. Once it fires, a programmed number of further samples is written and a "done" record closes the trace. Two other events end a trace. An optional timeout, counted in prescaled ticks, ends it as though a trigger had occurred but reports the auto token. A cancel ends it at once.

Every record carries a 2-bit token, the value of a free-running 32-bit timestamp counter and the address of the next sample to be written. Configuration inputs must stay stable while a trace runs.

Top module: `trace_ctrl`

## Requirements
- R1: A start pulse while idle makes the block busy and, one cycle later, presents a record with token 2 (waiting) whose address is the programmed start address. A start pulse while busy is ignored: it produces no record and does not restart the trace.
- R2: While busy, each valid sample that is not cancelled drives the write enable in the same cycle, with the data and the current write address. The address then advances by one and wraps from DEPTH-1 to 0.
- R3: The trigger qualifier ignores the first pre-count samples written after start.
- R4: A sample meets the trigger condition when every channel whose mask bit is 1 equals its level bit (1 = high, 0 = low). Channels with mask bit 0 are don't-care.
- R5: The trigger fires on the sample that completes a run of outro consecutive matching samples that directly follows a run of at least intro non-matching samples. A non-matching sample during the true run restarts the false run. An intro of 0 gives a level trigger. An outro of 0 acts as 1.
- R6: After the trigger sample, exactly post-count further samples are written. The record for the last of them has token 0 (done) and the address following it. With a post count of 0, the trigger sample itself closes the trace.
- R7: A non-zero timeout T ends the wait for a trigger exactly T*AUTO_TICK_CYC cycles after start, as though it were a trigger, and the final record uses token 1 (auto). A timeout of 0 never expires.
- R8: Cancel while busy ends the trace on that edge with a token 3 (stopped) record whose address is the next write address. A sample presented in the same cycle is not written.
- R9: Each record's timestamp is the free-running counter, which steps by one per clock and rolls over. The difference between two records equals the number of cycles between them.
- R10: In reset and while idle, the block is not busy, issues no record and does not write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a trace (ignored while busy) |
| cancel | input | 1 | Abort the running trace |
| smp_valid | input | 1 | Sample present this cycle |
| smp_data | input | CH_W | One bit per channel |
| cfg_start_addr | input | ADDR_W | Initial write address, below DEPTH |
| cfg_pre | input | CNT_W | Samples written before the qualifier arms |
| cfg_post | input | CNT_W | Samples written after the trigger sample |
| cfg_timeout | input | CNT_W | Auto timeout in ticks, 0 = none |
| cfg_mask | input | CH_W | Channel used by the trigger when 1 |
| cfg_level | input | CH_W | Target level per channel |
| cfg_intro | input | CNT_W | Required non-matching run length |
| cfg_outro | input | CNT_W | Required matching run length |
| busy | output | 1 | Trace in progress |
| wr_en | output | 1 | Buffer write strobe |
| wr_addr | output | ADDR_W | Buffer write address |
| wr_data | output | CH_W | Buffer write data |
| stat_valid | output | 1 | Status record present (one cycle) |
| stat_token | output | 2 | 0 done, 1 auto, 2 waiting, 3 stopped |
| stat_time | output | TS_W | Timestamp of the record |
| stat_addr | output | ADDR_W | Next write address (start address for waiting) |

## Verification
The write strobe, address and data are combinational from the sample inputs. The bench drives each sample just after a falling edge and checks them one time unit later, within that same cycle. Every status record is registered and appears after the edge that took the start, cancel, trigger, final post sample or timeout expiry. A monitor reads it at the next falling edge and compares it against a queue of expected records. Timestamps are checked as differences between consecutive records: for sample i counted from the start edge, the expected difference is i+1 cycles, and for a timeout it is T*AUTO_TICK_CYC. The bench issues no further samples after a terminating event, so an unexpected or missing record shows as a queue mismatch.

// File: rtl/trc_pkg.sv
package trc_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_SEEK = 2'd1,
      ST_POST = 2'd2
   } trc_state_e;

   typedef enum logic [1:0] {
      TOK_DONE = 2'd0,
      TOK_AUTO = 2'd1,
      TOK_WAIT = 2'd2,
      TOK_STOP = 2'd3
   } trc_token_e;

endpackage

// File: rtl/trc_timebase.sv
module trc_timebase #(
   parameter int TS_W = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   output logic [TS_W-1:0] ts
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ts <= '0;
      else        ts <= ts + 1'b1;
   end

endmodule

// File: rtl/trc_wr_ring.sv
module trc_wr_ring #(
   parameter int DEPTH  = 12288,
   parameter int ADDR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_addr,
   input  logic              adv,
   output logic [ADDR_W-1:0] ptr,
   output logic [ADDR_W-1:0] ptr_nxt
);

   localparam bit IS_POW2 = ((DEPTH & (DEPTH - 1)) == 0);
   localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

   generate
      if (IS_POW2) begin : g_pow2
         assign ptr_nxt = ptr + 1'b1;
      end else begin : g_mod
         assign ptr_nxt = (ptr == LAST) ? '0 : ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    ptr <= '0;
      else if (load) ptr <= load_addr;
      else if (adv)  ptr <= ptr_nxt;
   end

endmodule

// File: rtl/trc_trig_qual.sv
module trc_trig_qual #(
   parameter int CH_W  = 8,
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             eval,
   input  logic [CH_W-1:0]  smp,
   input  logic [CH_W-1:0]  mask,
   input  logic [CH_W-1:0]  level,
   input  logic [CNT_W-1:0] intro,
   input  logic [CNT_W-1:0] outro,
   output logic             fire
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   logic [CNT_W-1:0] f_run, t_run, t_next, outro_eff;
   logic             cond, intro_ok;

   assign cond      = (((smp ~^ level) & mask) == mask);
   assign intro_ok  = (f_run >= intro);
   assign outro_eff = (outro == '0) ? CNT_ONE : outro;
   assign t_next    = t_run + 1'b1;
   assign fire      = eval && cond && intro_ok && (t_next >= outro_eff);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         f_run <= '0;
         t_run <= '0;
      end else if (clear) begin
         f_run <= '0;
         t_run <= '0;
      end else if (eval) begin
         if (cond) begin
            if (intro_ok) t_run <= t_next;
            else          f_run <= '0;
         end else begin
            t_run <= '0;
            if (t_run != '0)          f_run <= CNT_ONE;
            else if (f_run != CNT_MAX) f_run <= f_run + 1'b1;
         end
      end
   end

endmodule

// File: rtl/trc_auto_timer.sv
module trc_auto_timer #(
   parameter int CNT_W    = 16,
   parameter int TICK_CYC = 256
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] limit,
   input  logic             run,
   output logic             expire
);

   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt;
   logic             tick;

   generate
      if (TICK_CYC == 1) begin : g_nodiv
         assign tick = 1'b1;
      end else begin : g_div
         localparam int DIV_W = $clog2(TICK_CYC);
         localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_CYC - 1);
         logic [DIV_W-1:0] div;
         assign tick = (div == DIV_LAST);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    div <= '0;
            else if (load) div <= '0;
            else if (run)  div <= tick ? '0 : div + 1'b1;
         end
      end
   endgenerate

   assign expire = run && tick && (cnt == CNT_ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          cnt <= '0;
      else if (load)                       cnt <= limit;
      else if (run && tick && cnt != '0)   cnt <= cnt - 1'b1;
   end

endmodule

// File: rtl/trace_ctrl.sv
module trace_ctrl
   import trc_pkg::*;
#(
   parameter int CH_W          = 8,
   parameter int DEPTH         = 12288,
   parameter int CNT_W         = 16,
   parameter int TS_W          = 32,
   parameter int AUTO_TICK_CYC = 256,
   localparam int ADDR_W       = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              cancel,
   input  logic              smp_valid,
   input  logic [CH_W-1:0]   smp_data,
   input  logic [ADDR_W-1:0] cfg_start_addr,
   input  logic [CNT_W-1:0]  cfg_pre,
   input  logic [CNT_W-1:0]  cfg_post,
   input  logic [CNT_W-1:0]  cfg_timeout,
   input  logic [CH_W-1:0]   cfg_mask,
   input  logic [CH_W-1:0]   cfg_level,
   input  logic [CNT_W-1:0]  cfg_intro,
   input  logic [CNT_W-1:0]  cfg_outro,
   output logic              busy,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [CH_W-1:0]   wr_data,
   output logic              stat_valid,
   output logic [1:0]        stat_token,
   output logic [TS_W-1:0]   stat_time,
   output logic [ADDR_W-1:0] stat_addr
);

   initial begin
      assert (DEPTH >= 2)        else $error("trace_ctrl: DEPTH must be at least 2");
      assert (CH_W >= 1)         else $error("trace_ctrl: CH_W must be positive");
      assert (CNT_W >= 2)        else $error("trace_ctrl: CNT_W too small");
      assert (TS_W >= 2)         else $error("trace_ctrl: TS_W too small");
      assert (AUTO_TICK_CYC >= 1) else $error("trace_ctrl: AUTO_TICK_CYC must be positive");
   end

   trc_state_e        state_q;
   logic [CNT_W-1:0]  pre_cnt_q, post_cnt_q;
   logic              auto_q;
   logic [ADDR_W-1:0] ptr, ptr_nxt, rec_addr;
   logic [TS_W-1:0]   ts_now;
   logic              active, wr_go, armed, q_eval, q_fire, t_expire, tmo_hit;
   logic              launch, post_last;

   assign active    = (state_q != ST_IDLE);
   assign launch    = (state_q == ST_IDLE) && start;
   assign wr_go     = active && smp_valid && !cancel;
   assign armed     = (pre_cnt_q >= cfg_pre);
   assign q_eval    = (state_q == ST_SEEK) && wr_go && armed;
   assign tmo_hit   = t_expire && !q_fire && !cancel;
   assign rec_addr  = wr_go ? ptr_nxt : ptr;
   assign post_last = (({1'b0, post_cnt_q} + 1'b1) == {1'b0, cfg_post});

   assign busy    = active;
   assign wr_en   = wr_go;
   assign wr_addr = ptr;
   assign wr_data = smp_data;

   trc_timebase #(.TS_W(TS_W)) u_time (
      .clk   (clk),
      .rst_n (rst_n),
      .ts    (ts_now)
   );

   trc_wr_ring #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ring (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (launch),
      .load_addr (cfg_start_addr),
      .adv       (wr_go),
      .ptr       (ptr),
      .ptr_nxt   (ptr_nxt)
   );

   trc_trig_qual #(.CH_W(CH_W), .CNT_W(CNT_W)) u_qual (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (launch),
      .eval  (q_eval),
      .smp   (smp_data),
      .mask  (cfg_mask),
      .level (cfg_level),
      .intro (cfg_intro),
      .outro (cfg_outro),
      .fire  (q_fire)
   );

   trc_auto_timer #(.CNT_W(CNT_W), .TICK_CYC(AUTO_TICK_CYC)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (launch),
      .limit  (cfg_timeout),
      .run    (state_q == ST_SEEK),
      .expire (t_expire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         pre_cnt_q  <= '0;
         post_cnt_q <= '0;
         auto_q     <= 1'b0;
         stat_valid <= 1'b0;
         stat_token <= '0;
         stat_time  <= '0;
         stat_addr  <= '0;
      end else begin
         stat_valid <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start) begin
                  state_q    <= ST_SEEK;
                  pre_cnt_q  <= '0;
                  post_cnt_q <= '0;
                  auto_q     <= 1'b0;
                  stat_valid <= 1'b1;
                  stat_token <= TOK_WAIT;
                  stat_time  <= ts_now;
                  stat_addr  <= cfg_start_addr;
               end
            end
            ST_SEEK: begin
               if (cancel) begin
                  state_q    <= ST_IDLE;
                  stat_valid <= 1'b1;
                  stat_token <= TOK_STOP;
                  stat_time  <= ts_now;
                  stat_addr  <= ptr;
               end else if (q_fire || tmo_hit) begin
                  auto_q     <= tmo_hit;
                  post_cnt_q <= '0;
                  if (cfg_post == '0) begin
                     state_q    <= ST_IDLE;
                     stat_valid <= 1'b1;
                     stat_token <= tmo_hit ? TOK_AUTO : TOK_DONE;
                     stat_time  <= ts_now;
                     stat_addr  <= rec_addr;
                  end else begin
                     state_q <= ST_POST;
                  end
               end else if (wr_go && !armed) begin
                  pre_cnt_q <= pre_cnt_q + 1'b1;
               end
            end
            ST_POST: begin
               if (cancel) begin
                  state_q    <= ST_IDLE;
                  stat_valid <= 1'b1;
                  stat_token <= TOK_STOP;
                  stat_time  <= ts_now;
                  stat_addr  <= ptr;
               end else if (wr_go) begin
                  if (post_last) begin
                     state_q    <= ST_IDLE;
                     stat_valid <= 1'b1;
                     stat_token <= auto_q ? TOK_AUTO : TOK_DONE;
                     stat_time  <= ts_now;
                     stat_addr  <= rec_addr;
                  end else begin
                     post_cnt_q <= post_cnt_q + 1'b1;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/trace_ctrl_chk.sv
module trace_ctrl_chk #(
   parameter int DEPTH  = 12288,
   parameter int ADDR_W = 14,
   parameter int TS_W   = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              cancel,
   input logic              busy,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic              stat_valid,
   input logic [1:0]        stat_token,
   input logic [TS_W-1:0]   ts_now
);

   localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

   a_r1_wait_on_start: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start) |=> (busy && stat_valid && stat_token == 2'd2));

   a_r1_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> !(stat_valid && stat_token == 2'd2));

   a_r2_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (wr_addr <= LAST));

   a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (!busy || wr_addr == (($past(wr_addr) == LAST) ? '0 : $past(wr_addr) + 1'b1)));

   a_r8_cancel_stop: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cancel) |=> (!busy && stat_valid && stat_token == 2'd3));

   a_r8_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      cancel |-> !wr_en);

   a_r9_ts_step: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (ts_now == $past(ts_now) + 1'b1));

   a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !wr_en);

endmodule

bind trace_ctrl trace_ctrl_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .TS_W(TS_W)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .start      (start),
   .cancel     (cancel),
   .busy       (busy),
   .wr_en      (wr_en),
   .wr_addr    (wr_addr),
   .stat_valid (stat_valid),
   .stat_token (stat_token),
   .ts_now     (ts_now)
);

// File: tb/trace_ctrl_tb_top.sv
module trace_ctrl_tb_top;

   localparam int CH_W   = 8;
   localparam int DEPTH  = 12288;
   localparam int CNT_W  = 16;
   localparam int TS_W   = 32;
   localparam int TICK   = 256;
   localparam int ADDR_W = $clog2(DEPTH);

   logic              clk = 1'b0;
   logic              rst_n;
   logic              start, cancel, smp_valid;
   logic [CH_W-1:0]   smp_data;
   logic [ADDR_W-1:0] cfg_start_addr;
   logic [CNT_W-1:0]  cfg_pre, cfg_post, cfg_timeout, cfg_intro, cfg_outro;
   logic [CH_W-1:0]   cfg_mask, cfg_level;
   logic              busy, wr_en, stat_valid;
   logic [ADDR_W-1:0] wr_addr, stat_addr;
   logic [CH_W-1:0]   wr_data;
   logic [1:0]        stat_token;
   logic [TS_W-1:0]   stat_time;

   always #4 clk = ~clk;

   trace_ctrl #(.CH_W(CH_W), .DEPTH(DEPTH), .CNT_W(CNT_W), .TS_W(TS_W),
                .AUTO_TICK_CYC(TICK)) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .cancel(cancel),
      .smp_valid(smp_valid), .smp_data(smp_data),
      .cfg_start_addr(cfg_start_addr), .cfg_pre(cfg_pre), .cfg_post(cfg_post),
      .cfg_timeout(cfg_timeout), .cfg_mask(cfg_mask), .cfg_level(cfg_level),
      .cfg_intro(cfg_intro), .cfg_outro(cfg_outro),
      .busy(busy), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .stat_valid(stat_valid), .stat_token(stat_token),
      .stat_time(stat_time), .stat_addr(stat_addr)
   );

   int          n_checks = 0;
   int          n_errors = 0;
   logic [1:0]  exp_tok[$];
   int          exp_addr[$];
   int          exp_dt[$];
   string       exp_tag[$];
   logic [TS_W-1:0] last_ts = '0;
   int          exp_ptr = 0;

   task automatic chk(input bit ok, input string tag, input string what,
                      input longint act, input longint expv);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
      end
   endtask

   task automatic push_rec(input logic [1:0] tok, input int addr, input int dt,
                           input string tag);
      exp_tok.push_back(tok);
      exp_addr.push_back(addr);
      exp_dt.push_back(dt);
      exp_tag.push_back(tag);
   endtask

   // monitor: pops one expected record per status pulse
   always @(negedge clk) begin
      if (rst_n === 1'b1 && stat_valid === 1'b1) begin
         if (exp_tok.size() == 0) begin
            n_checks++;
            n_errors++;
            $display("FAIL R1 unexpected record: actual token %0d addr %0d expected none",
                     stat_token, stat_addr);
         end else begin
            logic [1:0] t;
            int a, d;
            string g;
            t = exp_tok.pop_front();
            a = exp_addr.pop_front();
            d = exp_dt.pop_front();
            g = exp_tag.pop_front();
            chk(stat_token == t, g, "record token", stat_token, t);
            chk(int'(stat_addr) == a, g, "record address", stat_addr, a);
            if (d >= 0)
               chk(int'(stat_time - last_ts) == d, "R9", "timestamp delta",
                   stat_time - last_ts, d);
         end
         last_ts = stat_time;
      end
   end

   // one clock of stimulus; write port checked within the same cycle
   task automatic cyc(input bit v, input logic [CH_W-1:0] d, input bit st,
                      input bit cn, input bit exp_wr, input string tag);
      smp_valid = v;
      smp_data  = d;
      start     = st;
      cancel    = cn;
      #1;
      chk(wr_en == exp_wr, tag, "write enable", wr_en, exp_wr);
      if (exp_wr) begin
         chk(int'(wr_addr) == exp_ptr, "R2", "write address", wr_addr, exp_ptr);
         chk(wr_data == d, "R2", "write data", wr_data, d);
         exp_ptr = (exp_ptr == DEPTH - 1) ? 0 : exp_ptr + 1;
      end
      @(negedge clk);
      start  = 1'b0;
      cancel = 1'b0;
   endtask

   task automatic begin_trace(input int addr, input int pre, input int intro,
                              input int outro, input int post, input int tmo,
                              input logic [CH_W-1:0] msk, input logic [CH_W-1:0] lvl);
      cfg_start_addr = ADDR_W'(addr);
      cfg_pre        = CNT_W'(pre);
      cfg_intro      = CNT_W'(intro);
      cfg_outro      = CNT_W'(outro);
      cfg_post       = CNT_W'(post);
      cfg_timeout    = CNT_W'(tmo);
      cfg_mask       = msk;
      cfg_level      = lvl;
      exp_ptr        = addr;
      push_rec(2'd2, addr, -1, "R1");
      cyc(1'b0, '0, 1'b1, 1'b0, 1'b0, "R1");
      chk(busy == 1'b1, "R1", "busy after start", busy, 1);
   endtask

   task automatic finish_run;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [CH_W-1:0] seq2 [11];
      logic [CH_W-1:0] seq4 [8];
      seq2 = '{8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h01, 8'h01, 8'h35, 8'h7a, 8'hc4};
      seq4 = '{8'h00, 8'h01, 8'h01, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00};
      rst_n = 1'b0;
      start = 1'b0; cancel = 1'b0; smp_valid = 1'b0; smp_data = '0;
      cfg_start_addr = '0; cfg_pre = '0; cfg_post = '0; cfg_timeout = '0;
      cfg_mask = '0; cfg_level = '0; cfg_intro = '0; cfg_outro = '0;
      repeat (3) @(negedge clk);
      // R10: reset state
      chk(busy == 1'b0, "R10", "busy in reset", busy, 0);
      chk(stat_valid == 1'b0, "R10", "record in reset", stat_valid, 0);
      chk(wr_en == 1'b0, "R10", "write in reset", wr_en, 0);
      rst_n = 1'b1;
      @(negedge clk);
      cyc(1'b1, 8'h55, 1'b0, 1'b0, 1'b0, "R10");

      // R3 R5 R6: pre-count gating, edge qualifier, post count
      begin_trace(10, 2, 2, 2, 3, 0, 8'h01, 8'h01);
      push_rec(2'd0, 21, 11, "R6");
      for (int i = 0; i < 11; i++) cyc(1'b1, seq2[i], 1'b0, 1'b0, 1'b1, "R3");
      cyc(1'b0, '0, 1'b0, 1'b0, 1'b0, "R6");
      chk(busy == 1'b0, "R6", "idle after done", busy, 0);

      // R4 R5: mask/level, level trigger with outro 0 and post 0
      begin_trace(50, 0, 0, 0, 0, 0, 8'h0C, 8'h04);
      push_rec(2'd0, 52, 2, "R4");
      cyc(1'b1, 8'h0C, 1'b0, 1'b0, 1'b1, "R4");
      cyc(1'b1, 8'hF4, 1'b0, 1'b0, 1'b1, "R4");
      cyc(1'b0, '0, 1'b0, 1'b0, 1'b0, "R5");
      chk(busy == 1'b0, "R5", "idle after level trigger", busy, 0);

      // R5: broken true run restarts the false run
      begin_trace(100, 0, 1, 3, 1, 0, 8'h01, 8'h01);
      push_rec(2'd0, 108, 8, "R5");
      for (int i = 0; i < 8; i++) cyc(1'b1, seq4[i], 1'b0, 1'b0, 1'b1, "R5");
      cyc(1'b0, '0, 1'b0, 1'b0, 1'b0, "R5");

      // R2: wrap from DEPTH-1 to 0
      begin_trace(DEPTH - 2, 0, 0, 1, 2, 0, 8'h00, 8'h00);
      push_rec(2'd0, 1, 3, "R2");
      for (int i = 0; i < 3; i++) cyc(1'b1, CH_W'(8'hA0 + i), 1'b0, 1'b0, 1'b1, "R2");
      cyc(1'b0, '0, 1'b0, 1'b0, 1'b0, "R2");

      // R7: timeout of 3 ticks with no samples
      begin_trace(300, 0, 1, 1, 0, 3, 8'h01, 8'h01);
      push_rec(2'd1, 300, 3 * TICK, "R7");
      repeat (3 * TICK + 20) cyc(1'b0, '0, 1'b0, 1'b0, 1'b0, "R7");
      chk(busy == 1'b0, "R7", "idle after timeout", busy, 0);

      // R8 R1: cancel drops the same-cycle sample; start while busy ignored
      begin_trace(200, 0, 1, 1, 4, 0, 8'h80, 8'h80);
      push_rec(2'd3, 204, 5, "R8");
      cyc(1'b1, 8'h00, 1'b0, 1'b0, 1'b1, "R8");
      cyc(1'b1, 8'h01, 1'b0, 1'b0, 1'b1, "R8");
      cyc(1'b1, 8'h02, 1'b1, 1'b0, 1'b1, "R1");
      cyc(1'b1, 8'h03, 1'b0, 1'b0, 1'b1, "R8");
      cyc(1'b1, 8'h04, 1'b0, 1'b1, 1'b0, "R8");
      chk(busy == 1'b0, "R8", "idle after cancel", busy, 0);

      // R7: zero timeout never expires; then cancel
      begin_trace(400, 0, 1, 1, 0, 0, 8'h01, 8'h01);
      repeat (1000) cyc(1'b0, '0, 1'b0, 1'b0, 1'b0, "R7");
      chk(busy == 1'b1, "R7", "still busy with zero timeout", busy, 1);
      push_rec(2'd3, 400, 1001, "R8");
      cyc(1'b0, '0, 1'b0, 1'b1, 1'b0, "R8");
      chk(busy == 1'b0, "R8", "idle after cancel", busy, 0);

      repeat (3) cyc(1'b0, '0, 1'b0, 1'b0, 1'b0, "R10");
      chk(exp_tok.size() == 0, "R1", "records outstanding", exp_tok.size(), 0);
      finish_run();
   end

endmodule